// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block steps one DMA channel through a linked chain of transfer descriptors. Once the channel is enabled it asks for a descriptor, waits for the descriptor to arrive, starts one block transfer and waits for the data mover to report that the block is done. It then spends one cycle deciding what to do next: run the next descriptor, stop for a suspend, or end the chain.

Each descriptor brings two flags. The stop-after flag asks the channel to halt once that descriptor's block has finished. The end-of-chain flag marks the final descriptor. A resume command releases a halted channel. If the command arrives while the chain is still running, it is held as pending. The next stop that comes up is then skipped and the pending command is used up.

Dropping the channel enable returns the sequencer to idle from any state and discards a pending resume. Bus mastering, address generation, beat movement and descriptor storage belong to neighbouring blocks.

Top module: `dma_chain_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `busy`, `suspended`, `fetch_req` and `block_start` are all 0.
- R2: When `chan_en` is high and the sequencer is idle, `busy` rises at the next clock edge and `fetch_req` pulses high for exactly one cycle. Every later fetch request is also a single-cycle pulse.
- R3: `desc_valid` sampled high while a fetch is outstanding latches `desc_suspend` and `desc_last`. At the next edge it gives a single-cycle `block_start`. `desc_valid` at any other time is ignored and does not change the latched flags.
- R4: After `block_done`, the sequencer spends one decision cycle. If the latched stop-after flag is 0 and the end-of-chain flag is 0, `fetch_req` pulses at the next edge.
- R5: If the latched stop-after flag is 1, the end-of-chain flag is 0 and no resume is pending, `suspended` goes to 1 after the decision cycle. `busy` stays 1, and no fetch is issued until a resume arrives.
- R6: A `resume_cmd` sampled while suspended clears `suspended` and pulses `fetch_req` at that same edge.
- R7: A `resume_cmd` sampled while fetching, transferring or deciding is held as pending. It makes the next stop-after descriptor skip its stop and fetch directly. Skipping uses up the pending resume, so a later stop-after descriptor stops again.
- R8: After the block of an end-of-chain descriptor completes, `busy` falls after the decision cycle. It stays low, with no fetch, while `chan_en` is held high. The end-of-chain flag takes precedence over the stop-after flag.
- R9: `chan_en` sampled low from any state makes all four outputs 0 at the next edge and discards any pending resume.
- R10: `resume_cmd` while idle or after the chain has ended is ignored. It does not carry into the next chain.
- R11: `block_done` is ignored unless a block transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low forces idle |
| resume_cmd | input | 1 | Resume command pulse |
| desc_valid | input | 1 | Requested descriptor has arrived |
| desc_suspend | input | 1 | Stop-after flag of the arriving descriptor |
| desc_last | input | 1 | End-of-chain flag of the arriving descriptor |
| block_done | input | 1 | Data mover finished the current block |
| busy | output | 1 | Channel is working through a chain (includes suspended) |
| suspended | output | 1 | Channel is halted waiting for resume |
| fetch_req | output | 1 | Single-cycle descriptor fetch request |
| block_start | output | 1 | Single-cycle block transfer start |

## Verification
The assertions assume that every input is synchronous to `clk` and that reset is held for at least one edge. Apart from that, they take nothing for granted about the inputs: stray `desc_valid`, `block_done` and `resume_cmd` pulses are legal in any state. The bench changes inputs only on the falling edge and keeps each of them to a single-cycle pulse. It also deliberately places stray pulses in states that must ignore them: `block_done` during a fetch, `desc_valid` carrying both flags set during a transfer, and `resume_cmd` after the chain has ended. It sweeps every chain length from one to four, every stop-after pattern and every early-resume pattern.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int SEQ_STATE_W = 3;

  typedef enum logic [SEQ_STATE_W-1:0] {
    SQ_IDLE    = 3'd0,
    SQ_FETCH   = 3'd1,
    SQ_XFER    = 3'd2,
    SQ_DECIDE  = 3'd3,
    SQ_HALTED  = 3'd4,
    SQ_FINISH  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dma_seq_resume.sv
module dma_seq_resume
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic       resume_cmd,
  input  seq_state_e st,
  input  logic       consume,
  output logic       resume_avail
);
  logic pend_q;
  logic armed;
  logic flush;

  // A command is remembered only while a chain is actively running.
  assign armed = (st == SQ_FETCH) || (st == SQ_XFER) ||
                 (st == SQ_DECIDE) || (st == SQ_HALTED);
  assign flush = !chan_en || (st == SQ_IDLE) || (st == SQ_FINISH);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_q <= 1'b0;
    end else if (consume) begin
      pend_q <= 1'b0;
    end else if (resume_cmd && armed) begin
      pend_q <= 1'b1;
    end
  end

  assign resume_avail = pend_q || (resume_cmd && armed);

  AST_PEND_USED_UP: assert property (@(posedge clk) disable iff (rst)
    consume |=> !pend_q); // R7
  AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !pend_q); // R9
  AST_PEND_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE) |=> !pend_q); // R10
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic       desc_valid,
  input  logic       desc_suspend,
  input  logic       desc_last,
  input  logic       block_done,
  input  logic       resume_avail,
  output seq_state_e st,
  output seq_state_e nxt,
  output logic       consume
);
  seq_state_e st_q;
  logic       stop_q;
  logic       end_q;
  logic       take_desc;

  assign take_desc = (st_q == SQ_FETCH) && desc_valid;

  always_comb begin
    nxt = st_q;
    if (!chan_en) begin
      nxt = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE:   nxt = SQ_FETCH;
        SQ_FETCH:  if (desc_valid) nxt = SQ_XFER;
        SQ_XFER:   if (block_done) nxt = SQ_DECIDE;
        SQ_DECIDE: begin
          if (end_q)                       nxt = SQ_FINISH;
          else if (stop_q && !resume_avail) nxt = SQ_HALTED;
          else                             nxt = SQ_FETCH;
        end
        SQ_HALTED: if (resume_avail) nxt = SQ_FETCH;
        SQ_FINISH: nxt = SQ_FINISH;
        default:   nxt = SQ_IDLE;
      endcase
    end
  end

  // A pending resume is spent either by skipping a stop or by leaving the halt.
  assign consume = ((st_q == SQ_DECIDE) && !end_q && stop_q && resume_avail) ||
                   ((st_q == SQ_HALTED) && resume_avail);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      stop_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      st_q <= nxt;
      if (take_desc) begin
        stop_q <= desc_suspend;
        end_q  <= desc_last;
      end
    end
  end

  assign st = st_q;

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q != SQ_FETCH) |=> ($stable(stop_q) && $stable(end_q))); // R3
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HALTED && chan_en && !resume_avail) |=> (st_q == SQ_HALTED)); // R5
  AST_FINISH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_FINISH && chan_en) |=> (st_q == SQ_FINISH)); // R8
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_FETCH && !desc_valid && chan_en) |=> (st_q == SQ_FETCH)); // R11
endmodule

// File: rtl/dma_seq_outreg.sv
module dma_seq_outreg
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  seq_state_e st,
  input  seq_state_e nxt,
  output logic       busy,
  output logic       suspended,
  output logic       fetch_req,
  output logic       block_start
);
  logic busy_d;

  assign busy_d = (nxt == SQ_FETCH) || (nxt == SQ_XFER) ||
                  (nxt == SQ_DECIDE) || (nxt == SQ_HALTED);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      suspended   <= 1'b0;
      fetch_req   <= 1'b0;
      block_start <= 1'b0;
    end else begin
      busy        <= busy_d;
      suspended   <= (nxt == SQ_HALTED);
      fetch_req   <= (nxt == SQ_FETCH) && (st != SQ_FETCH);
      block_start <= (nxt == SQ_XFER) && (st != SQ_XFER);
    end
  end

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> !fetch_req); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    block_start |=> !block_start); // R3
  AST_HALT_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
    suspended |-> busy); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!busy && !suspended && !fetch_req && !block_start)); // R9
  AST_NO_FETCH_HALTED: assert property (@(posedge clk) disable iff (rst)
    suspended |-> !fetch_req); // R5
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic resume_cmd,
  input  logic desc_valid,
  input  logic desc_suspend,
  input  logic desc_last,
  input  logic block_done,
  output logic busy,
  output logic suspended,
  output logic fetch_req,
  output logic block_start
);
  seq_state_e st;
  seq_state_e nxt;
  logic       consume;
  logic       resume_avail;

  dma_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .chan_en      (chan_en),
    .desc_valid   (desc_valid),
    .desc_suspend (desc_suspend),
    .desc_last    (desc_last),
    .block_done   (block_done),
    .resume_avail (resume_avail),
    .st           (st),
    .nxt          (nxt),
    .consume      (consume)
  );

  dma_seq_resume u_resume (
    .clk          (clk),
    .rst          (rst),
    .chan_en      (chan_en),
    .resume_cmd   (resume_cmd),
    .st           (st),
    .consume      (consume),
    .resume_avail (resume_avail)
  );

  dma_seq_outreg u_out (
    .clk         (clk),
    .rst         (rst),
    .chan_en     (chan_en),
    .st          (st),
    .nxt         (nxt),
    .busy        (busy),
    .suspended   (suspended),
    .fetch_req   (fetch_req),
    .block_start (block_start)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !suspended && !fetch_req && !block_start)); // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    block_start |-> busy); // R3
endmodule

// File: tb/tb_dma_chain_seq.sv
`timescale 1ns/1ps
module tb_dma_chain_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b0;
  logic resume_cmd = 1'b0;
  logic desc_valid = 1'b0;
  logic desc_suspend = 1'b0;
  logic desc_last = 1'b0;
  logic block_done = 1'b0;
  logic busy, suspended, fetch_req, block_start;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  dma_chain_seq dut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .resume_cmd(resume_cmd),
    .desc_valid(desc_valid), .desc_suspend(desc_suspend), .desc_last(desc_last),
    .block_done(block_done), .busy(busy), .suspended(suspended),
    .fetch_req(fetch_req), .block_start(block_start)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic run_chain(input int len, input int smask, input int emask);
    bit pend = 1'b0;
    chan_en = 1'b1;
    tick;
    chk("R2", "busy on enable", busy, 1'b1);
    chk("R2", "first fetch_req", fetch_req, 1'b1);
    for (int i = 0; i < len; i++) begin
      bit st_f = smask[i];
      bit ls_f = (i == len - 1);
      if (i == 0) begin
        block_done = 1'b1;
        tick;
        block_done = 1'b0;
        chk("R11", "no start on stray done", block_start, 1'b0);
        chk("R2", "fetch_req single pulse", fetch_req, 1'b0);
        chk("R11", "busy kept", busy, 1'b1);
      end
      desc_valid = 1'b1; desc_suspend = st_f; desc_last = ls_f;
      tick;
      chk("R3", "block_start after desc", block_start, 1'b1);
      chk("R2", "no fetch during start", fetch_req, 1'b0);
      // stray descriptor with both flags set during the transfer
      desc_valid = 1'b1; desc_suspend = 1'b1; desc_last = 1'b1;
      resume_cmd = emask[i];
      tick;
      desc_valid = 1'b0; desc_suspend = 1'b0; desc_last = 1'b0;
      resume_cmd = 1'b0;
      chk("R3", "stray desc ignored", block_start, 1'b0);
      if (emask[i]) pend = 1'b1;
      block_done = 1'b1;
      tick;
      block_done = 1'b0;
      chk("R4", "busy in decision", busy, 1'b1);
      chk("R4", "no fetch in decision", fetch_req, 1'b0);
      tick;
      if (ls_f) begin
        chk("R8", "busy drops at end", busy, 1'b0);
        chk("R8", "not suspended at end", suspended, 1'b0);
        chk("R8", "no fetch at end", fetch_req, 1'b0);
      end else if (st_f && !pend) begin
        chk("R5", "suspended", suspended, 1'b1);
        chk("R5", "busy while suspended", busy, 1'b1);
        chk("R5", "no fetch suspended", fetch_req, 1'b0);
        tick; tick;
        chk("R5", "still suspended", suspended, 1'b1);
        chk("R5", "still no fetch", fetch_req, 1'b0);
        resume_cmd = 1'b1;
        tick;
        resume_cmd = 1'b0;
        chk("R6", "suspended cleared", suspended, 1'b0);
        chk("R6", "fetch after resume", fetch_req, 1'b1);
      end else begin
        if (st_f) pend = 1'b0;
        chk(st_f ? "R7" : "R4", "fetch next", fetch_req, 1'b1);
        chk(st_f ? "R7" : "R4", "no suspend", suspended, 1'b0);
        chk("R4", "busy continues", busy, 1'b1);
      end
    end
    tick;
    chk("R8", "stays not busy", busy, 1'b0);
    chk("R8", "no refetch", fetch_req, 1'b0);
    resume_cmd = 1'b1;
    tick;
    resume_cmd = 1'b0;
    chk("R10", "resume after end ignored", busy, 1'b0);
    chk("R10", "no fetch after late resume", fetch_req, 1'b0);
    chan_en = 1'b0;
    tick;
    tick;
    chk("R9", "idle after disable", busy, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !ended) begin
        ended = 1'b1;
        bad++;
        total++;
        $display("FAIL R0 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tick; tick;
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "suspended in reset", suspended, 1'b0);
    chk("R1", "fetch_req in reset", fetch_req, 1'b0);
    chk("R1", "block_start in reset", block_start, 1'b0);
    rst = 1'b0;
    tick;
    chk("R1", "busy after reset", busy, 1'b0);
    resume_cmd = 1'b1;
    tick;
    resume_cmd = 1'b0;
    chk("R10", "resume idle ignored", busy, 1'b0);

    for (int len = 1; len <= 4; len++)
      for (int s = 0; s < (1 << len); s++)
        for (int e = 0; e < (1 << len); e++)
          run_chain(len, s, e);

    // disable mid-transfer with a pending resume
    chan_en = 1'b1;
    tick;
    desc_valid = 1'b1; desc_suspend = 1'b1; desc_last = 1'b0;
    tick;
    desc_valid = 1'b0; desc_suspend = 1'b0;
    resume_cmd = 1'b1;
    tick;
    resume_cmd = 1'b0;
    chan_en = 1'b0;
    tick;
    chk("R9", "busy off mid-transfer", busy, 1'b0);
    chk("R9", "block_start off", block_start, 1'b0);
    chk("R9", "fetch off", fetch_req, 1'b0);
    tick;
    chan_en = 1'b1;
    tick;
    chk("R9", "re-enable fetches", fetch_req, 1'b1);
    desc_valid = 1'b1; desc_suspend = 1'b1; desc_last = 1'b0;
    tick;
    desc_valid = 1'b0; desc_suspend = 1'b0;
    block_done = 1'b1;
    tick;
    block_done = 1'b0;
    tick;
    chk("R9", "pending resume discarded", suspended, 1'b1);
    chan_en = 1'b0;
    tick;
    chk("R9", "suspended off on disable", suspended, 1'b0);
    chk("R9", "busy off on disable", busy, 1'b0);
    tick;

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule